// File: doc/BRIEF.md
# Eight-bit event timer with shared prescaler

The block holds an 8-bit count register that the processor reads and writes over a simple data port. The register advances either once per instruction-cycle strobe or on a chosen edge of an external pin. The pin is first brought into the core clock domain by a two-stage synchroniser, and an edge detector then picks rising or falling transitions. A power-of-two prescaler, with eight ratios from 1:2 to 1:256, may be placed in front of the count register. It may instead be lent to a watchdog path, which drives it with its own event input and sees only a registered output tap.

A control register sets the source, the edge, where the prescaler sits and its ratio. A bus write to the count register loads the new value, holds off counting for the next two instruction-cycle strobes, and clears the prescaler when the prescaler serves the counter. Passing from 0xFF to 0x00 raises a single-cycle overflow pulse.

Top module: `evt_timer8`

## Requirements
- R1: After reset, count_o is 0x00, ovf_o and wdt_tap_o are 0, the prescaler count is zero, and ctrl_q_o reads 0x3F: external source, falling edge, prescaler on the watchdog, ratio field 7.
- R2: With ctrl bit 5 = 0 and ctrl bit 3 = 1, count_o rises by one at each clock edge where tick_i is high.
- R3: With ctrl bit 5 = 1, the count advances on pin edges: rising edges when ctrl bit 4 = 0 and falling edges when it is 1. A pin change made before clock edge k shows in count_o after edge k+2. tick_i has no effect in this mode.
- R4: With ctrl bit 3 = 0, the count advances once for every 2^(ctrl[2:0]+1) source events. The count steps on the event that finds the low ctrl[2:0]+1 bits of the prescaler count all ones.
- R5: A cycle with wr_en_i high loads wr_data_i into count_o after that edge. Increment events are ignored until two further tick_i pulses have occurred after the write cycle, including the event in the cycle of the second pulse.
- R6: A count write while ctrl bit 3 = 0 resets the prescaler count to zero. The prescaler keeps counting source events during the hold-off.
- R7: An increment from 0xFF gives count_o = 0x00 and ovf_o high for exactly that one cycle.
- R8: With ctrl bit 3 = 1, the prescaler counts wdt_evt_i pulses. wdt_tap_o goes high for one cycle after every 2^(ctrl[2:0]+1)-th pulse, and wdt_evt_i does not affect the count. With ctrl bit 3 = 0, wdt_tap_o stays 0.
- R9: A cycle with ctrl_we_i high loads ctrl_d_i into the control register, and ctrl_q_o reads it back after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_d_i | input | 6 | Control write data: [5] source, [4] edge, [3] prescaler owner, [2:0] ratio |
| ctrl_q_o | output | 6 | Control register contents |
| tick_i | input | 1 | Instruction-cycle strobe |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| wdt_evt_i | input | 1 | Watchdog event input to the prescaler |
| wr_en_i | input | 1 | Count register write enable |
| wr_data_i | input | 8 | Count register write data |
| count_o | output | 8 | Count register value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| wdt_tap_o | output | 1 | Registered prescaler output toward the watchdog |

## Verification
The sharpest collision is a bus write landing in the same cycle as an increment event. The event may be a strobe, a synchronised pin edge or a prescaler terminal count, and the load must win, start the hold-off and clear the prescaler. Random traffic makes writes, strobes, pin toggles and control changes overlap freely. Directed sequences place a write right after a pre-advanced prescaler and a write on a 0xFE count. Every cycle, a bench reference model restates the requirements and judges count_o, ovf_o and wdt_tap_o.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
  localparam int RATIO_W = 3;
  localparam int PS_W    = 2 ** RATIO_W;
  localparam int CTRL_W  = RATIO_W + 3;

  typedef struct packed {
    logic               src_pin;
    logic               fall_edge;
    logic               ps_to_wdt;
    logic [RATIO_W-1:0] ratio;
  } tc_ctrl_t;

  localparam tc_ctrl_t CTRL_RST = '1;
endpackage

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              lvl_prev;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain    <= '0;
      lvl_prev <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], pin_i};
      lvl_prev <= lvl;
    end
  end

  assign lvl    = chain[STAGES-1];
  assign edge_o = fall_sel_i ? (lvl_prev & ~lvl) : (lvl & ~lvl_prev);
endmodule

// File: rtl/tc8_prescaler.sv
module tc8_prescaler
  import tc8_pkg::*;
#(
  parameter int W = PS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_i,
  input  logic               clr_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               out_o
);
  logic [W-1:0] pcnt;

  function automatic logic at_terminal(input logic [W-1:0] c, input logic [RATIO_W-1:0] r);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (i <= int'(r)) hit = hit & c[i];
    end
    return hit;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     pcnt <= '0;
    else if (clr_i) pcnt <= '0;
    else if (evt_i) pcnt <= pcnt + 1'b1;
  end

  assign out_o = evt_i & at_terminal(pcnt, ratio_i);
endmodule

// File: rtl/tc8_counter.sv
module tc8_counter #(
  parameter int W     = 8,
  parameter int STALL = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o,
  output logic         hold_o
);
  localparam int SW = $clog2(STALL + 1);

  logic [SW-1:0] stall_q;
  logic [W-1:0]  cnt_q;
  logic          ovf_q;

  function automatic logic wraps(input logic [W-1:0] c);
    return &c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_i) begin
        cnt_q   <= wd_i;
        stall_q <= SW'(STALL);
      end else begin
        if (stall_q != '0 && tick_i) stall_q <= stall_q - 1'b1;
        if (evt_i && stall_q == '0) begin
          cnt_q <= cnt_q + 1'b1;
          ovf_q <= wraps(cnt_q);
        end
      end
    end
  end

  assign hold_o  = (stall_q != '0);
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import tc8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WR_STALL    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_d_i,
  output logic [CTRL_W-1:0] ctrl_q_o,
  input  logic              tick_i,
  input  logic              ext_pin_i,
  input  logic              wdt_evt_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic              wdt_tap_o
);
  tc_ctrl_t ctrl_q;
  logic     pin_edge;
  logic     src_evt;
  logic     ps_in;
  logic     ps_tick;
  logic     ps_clr;
  logic     cnt_evt;
  logic     cnt_hold;
  logic     tap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= CTRL_RST;
    else if (ctrl_we_i) ctrl_q <= tc_ctrl_t'(ctrl_d_i);
  end

  tc8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (ext_pin_i),
    .fall_sel_i(ctrl_q.fall_edge),
    .edge_o    (pin_edge)
  );

  assign src_evt = ctrl_q.src_pin ? pin_edge : tick_i;
  assign ps_in   = ctrl_q.ps_to_wdt ? wdt_evt_i : src_evt;
  assign ps_clr  = wr_en_i & ~ctrl_q.ps_to_wdt;

  tc8_prescaler #(.W(PS_W)) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (ps_in),
    .clr_i  (ps_clr),
    .ratio_i(ctrl_q.ratio),
    .out_o  (ps_tick)
  );

  assign cnt_evt = ctrl_q.ps_to_wdt ? src_evt : ps_tick;

  tc8_counter #(.W(CNT_W), .STALL(WR_STALL)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (cnt_evt),
    .tick_i (tick_i),
    .wr_i   (wr_en_i),
    .wd_i   (wr_data_i),
    .count_o(count_o),
    .ovf_o  (ovf_o),
    .hold_o (cnt_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tap_q <= 1'b0;
    else        tap_q <= ctrl_q.ps_to_wdt & ps_tick;
  end

  assign wdt_tap_o = tap_q;
  assign ctrl_q_o  = ctrl_q;
endmodule

// File: rtl/tc8_checker.sv
module tc8_checker #(
  parameter int CNT_W  = 8,
  parameter int CTRL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_q_o,
  input logic              wr_en_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              ovf_o,
  input logic              wdt_tap_o,
  input logic              cnt_hold,
  input logic              ps_tick
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count_o == '0 && ctrl_q_o == '1 && !ovf_o && !wdt_tap_o));

  a_r2_step_le_one: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  a_r4_ps_drives_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q_o[3] && !wr_en_i && !cnt_hold && ps_tick) |=> count_o == $past(count_o) + 1'b1);

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> count_o == $past(wr_data_i));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && cnt_hold) |=> $stable(count_o));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (count_o == '0 && $past(count_o) == '1));

  a_r8_tap_owner: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tap_o |-> $past(ctrl_q_o[3]));
endmodule

bind evt_timer8 tc8_checker #(.CNT_W(CNT_W), .CTRL_W(tc8_pkg::CTRL_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_q_o (ctrl_q_o),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .count_o  (count_o),
  .ovf_o    (ovf_o),
  .wdt_tap_o(wdt_tap_o),
  .cnt_hold (cnt_hold),
  .ps_tick  (ps_tick)
);

// File: tb/test_evt_timer8.sv
module test_evt_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [5:0] ctrl_d_i = '0;
  logic [5:0] ctrl_q_o;
  logic       tick_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       wdt_evt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] count_o;
  logic       ovf_o;
  logic       wdt_tap_o;

  int checks = 0;
  int errors = 0;
  int base;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_timer8 i_evt_timer8 (
    .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we_i), .ctrl_d_i(ctrl_d_i),
    .ctrl_q_o(ctrl_q_o), .tick_i(tick_i), .ext_pin_i(ext_pin_i),
    .wdt_evt_i(wdt_evt_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .count_o(count_o), .ovf_o(ovf_o), .wdt_tap_o(wdt_tap_o)
  );

  // reference model, restated from the requirements
  logic [5:0] m_ctrl;
  logic       m_p1, m_p2, m_p3;
  logic [7:0] m_ps;
  logic [7:0] m_cnt;
  int         m_wait;
  logic       m_ovf, m_tap;

  function automatic int divisor(input logic [2:0] r);
    return 1 << (int'(r) + 1);
  endfunction

  function automatic bit ps_fires(input logic [7:0] p, input logic [2:0] r);
    return ((int'(p) + 1) % divisor(r)) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 6'h3F; m_p1 = 0; m_p2 = 0; m_p3 = 0; m_ps = 0;
      m_cnt = 0; m_wait = 0; m_ovf = 0; m_tap = 0;
    end else begin
      bit pin_ev, src_ev, ps_ev, ps_out, inc;
      pin_ev = m_ctrl[4] ? (m_p3 && !m_p2) : (m_p2 && !m_p3);
      src_ev = m_ctrl[5] ? pin_ev : tick_i;
      ps_ev  = m_ctrl[3] ? wdt_evt_i : src_ev;
      ps_out = ps_ev && ps_fires(m_ps, m_ctrl[2:0]);
      inc    = m_ctrl[3] ? src_ev : ps_out;
      m_tap  = m_ctrl[3] && ps_out;
      m_ovf  = 0;
      if (wr_en_i) begin
        m_cnt = wr_data_i; m_wait = 2;
      end else if (m_wait > 0) begin
        if (tick_i) m_wait--;
      end else if (inc) begin
        m_ovf = (m_cnt == 8'hFF);
        m_cnt = m_cnt + 8'd1;
      end
      if (wr_en_i && !m_ctrl[3]) m_ps = 0;
      else if (ps_ev)            m_ps = m_ps + 8'd1;
      if (ctrl_we_i) m_ctrl = ctrl_d_i;
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit pin, input bit wr, input logic [7:0] wd,
                      input bit wdt, input bit cwe, input logic [5:0] cd);
    tick_i = tk; ext_pin_i = pin; wr_en_i = wr; wr_data_i = wd;
    wdt_evt_i = wdt; ctrl_we_i = cwe; ctrl_d_i = cd;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input bit tk, input bit pin);
    step(tk, pin, 0, 8'h00, 0, 0, 6'h00);
  endtask

  task automatic set_ctrl(input logic [5:0] v, input bit pin);
    step(0, pin, 0, 8'h00, 0, 1, v);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(0, 0);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 ctrl", ctrl_q_o, 6'h3F);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 tap", wdt_tap_o, 0);

    // R8 watchdog owns prescaler, ratio 1 (divide by 4); R9 readback
    set_ctrl(6'h09, 0);
    chk("R9 ctrl readback", ctrl_q_o, 6'h09);
    for (int i = 1; i <= 4; i++) begin
      step(0, 0, 0, 8'h00, 1, 0, 6'h00);
      chk("R8 tap", wdt_tap_o, (i == 4) ? 1 : 0);
    end
    chk("R8 wdt does not count", count_o, 0);

    // R2 timer mode
    for (int i = 0; i < 10; i++) idle(1, 0);
    chk("R2 ten ticks", count_o, 10);

    // R5 write and two-tick hold-off
    step(1, 0, 1, 8'h40, 0, 0, 6'h00);
    chk("R5 load", count_o, 8'h40);
    idle(1, 0); chk("R5 hold 1", count_o, 8'h40);
    idle(1, 0); chk("R5 hold 2", count_o, 8'h40);
    idle(1, 0); chk("R5 resume", count_o, 8'h41);

    // R7 overflow
    step(0, 0, 1, 8'hFE, 0, 0, 6'h00);
    idle(1, 0); idle(1, 0);
    idle(1, 0); chk("R7 ff", count_o, 8'hFF); chk("R7 no ovf", ovf_o, 0);
    idle(1, 0); chk("R7 wrap", count_o, 0); chk("R7 ovf", ovf_o, 1);
    idle(0, 0); chk("R7 ovf one cycle", ovf_o, 0);

    // R3 pin rising, ticks ignored
    set_ctrl(6'h28, 0);
    base = count_o;
    idle(1, 1); chk("R3 sync 1", count_o, base);
    idle(1, 1); chk("R3 sync 2", count_o, base);
    idle(1, 1); chk("R3 rise counted", count_o, (base + 1) % 256);
    for (int i = 0; i < 4; i++) idle(1, 0);
    chk("R3 fall ignored", count_o, (base + 1) % 256);
    set_ctrl(6'h38, 0);
    for (int i = 0; i < 4; i++) idle(0, 1);
    chk("R3 rise ignored", count_o, (base + 1) % 256);
    idle(0, 0); idle(0, 0);
    chk("R3 fall sync", count_o, (base + 1) % 256);
    idle(0, 0); chk("R3 fall counted", count_o, (base + 2) % 256);

    // R4 prescaler on counter, divide by 4
    set_ctrl(6'h01, 0);
    step(0, 0, 1, 8'h10, 0, 0, 6'h00);
    idle(1, 0); idle(1, 0); idle(1, 0);
    chk("R4 before terminal", count_o, 8'h10);
    idle(1, 0); chk("R4 terminal", count_o, 8'h11);
    for (int i = 0; i < 4; i++) idle(1, 0);
    chk("R4 next four", count_o, 8'h12);

    // R6 write clears a pre-advanced prescaler
    idle(1, 0);
    step(0, 0, 1, 8'h20, 0, 0, 6'h00);
    idle(1, 0); idle(1, 0); idle(1, 0);
    chk("R6 cleared third tick", count_o, 8'h20);
    idle(1, 0); chk("R6 cleared fourth tick", count_o, 8'h21);

    // R8 tap silent while prescaler serves the counter
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0, 8'h00, 1, 0, 6'h00);
      chk("R8 tap off", wdt_tap_o, 0);
    end

    // random mix against the reference model
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4000; i++) begin
      bit pin;
      pin = ($urandom % 5 == 0) ? ~ext_pin_i : ext_pin_i;
      step($urandom % 2, pin, ($urandom % 20) == 0, 8'($urandom),
           ($urandom % 3) == 0, ($urandom % 40) == 0, 6'($urandom));
      chk("R2/R3/R4/R5/R6 count", count_o, m_cnt);
      chk("R7 ovf", ovf_o, m_ovf);
      chk("R8 tap", wdt_tap_o, m_tap);
      chk("R9 ctrl", ctrl_q_o, m_ctrl);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule